// File: doc/BRIEF.md
# Write Protection Command Sequencer

This block watches the byte-load stream of a paged nonvolatile memory and decides what happens to each loaded byte. A load starts with its first byte strobe and ends once no new byte has arrived for a configurable number of clock cycles. Keyed address/data sequences at the start of a load are recognised. A three-byte sequence arms write protection, or unlocks one load while protection is already on. A six-byte sequence turns protection off. Sequence bytes are consumed as commands and never reach the page buffer.

The sequencer gates each ordinary byte through a protection flag. It tells the page-write controller which bytes to latch, when the load has closed, and whether the timed write cycle that follows should program the array or only run as a dummy. A dummy cycle keeps the device busy so that reads behave as status polls. Changes to the flag take effect when the controller reports the end of the timed cycle. The flag itself is held in a register that reset leaves alone, which models nonvolatile retention. It starts out cleared.

Top module: `wps_seq`

## Requirements
- R1: When a load begins with data 0xAA to address 0x5555, then 0x55 to 0x2AAA, then 0xA0 to 0x5555, each of the three bytes raises cmd_o with store_o low in the cycle its strobe is high.
- R2: When a load begins with 0xAA@0x5555, 0x55@0x2AAA, 0x80@0x5555, 0xAA@0x5555, 0x55@0x2AAA, 0x20@0x5555, each of the six bytes raises cmd_o with store_o low.
- R3: After the three-byte arming sequence, the closing load starts a cycle even when no data byte followed, and prot_o rises only after cycle_done_i ends that cycle.
- R4: After the six-byte sequence, the closing load starts a cycle, and prot_o falls only after cycle_done_i ends that cycle.
- R5: While prot_o is high, a byte in a load without the arming sequence in front has cmd_o and store_o low; the load still starts a cycle with program_o low, and prot_o stays high.
- R6: While prot_o is high, bytes that follow the arming sequence in the same load raise store_o, the cycle starts with program_o high, and prot_o stays high afterwards.
- R7: While prot_o is low, ordinary bytes raise store_o, and the cycle starts with program_o high.
- R8: A byte that does not fit the next sequence step aborts the partial match and is treated as an ordinary byte. Matching resumes from the first step in the next load.
- R9: A load that holds only a partial sequence starts no cycle when it times out, leaves prot_o unchanged, and the next load matches afresh.
- R10: start_cycle_o pulses for one cycle exactly LOAD_WINDOW cycles after the last byte of a load, and busy_o is high from the next cycle.
- R11: While busy_o is high, byte strobes raise neither cmd_o nor store_o and change no state.
- R12: The flag is low after power-up, and asserting rst_ni does not clear a set flag.
- R13: Once a sequence has completed in a load, later bytes of that load are data, even if they equal the first sequence step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset (does not touch the flag) |
| wr_valid_i | input | 1 | Byte-load strobe, one cycle per byte |
| wr_addr_i | input | ADDR_W | Byte address |
| wr_data_i | input | DATA_W | Byte data |
| cycle_done_i | input | 1 | Timed write cycle finished |
| cmd_o | output | 1 | Current byte is a sequence byte, not to be stored |
| store_o | output | 1 | Current byte is to be latched into the page buffer |
| start_cycle_o | output | 1 | Load closed; start the timed cycle |
| program_o | output | 1 | The cycle programs the array (low: dummy cycle) |
| busy_o | output | 1 | Timed cycle in progress |
| prot_o | output | 1 | Write protection flag |

## Verification
The bench goes after the borders of a sequence. An arming sequence followed by no data must still produce a dummy cycle and set the flag; a design that skipped it would leave the memory unprotected. A sequence broken on its second or third byte must store the breaking byte; a design that swallowed it would lose a user write. A load that repeats 0xAA@0x5555 after a completed sequence must store it rather than restart matching. Protected loads without the prefix must run a non-programming cycle, strobes during the busy period must be ignored, and a reset while protected must keep the flag; a design that got any of these wrong would show the wrong store, program or flag value at the ports.

// File: rtl/wps_pkg.sv
package wps_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_BUSY} wps_state_e;
  typedef enum logic [1:0] {ACT_NONE, ACT_SET, ACT_CLR} wps_act_e;

  localparam int unsigned CODE_W = 8;
  localparam logic [CODE_W-1:0] CODE_LEAD   = 8'hAA;
  localparam logic [CODE_W-1:0] CODE_FOLLOW = 8'h55;
  localparam logic [CODE_W-1:0] CODE_SET    = 8'hA0;
  localparam logic [CODE_W-1:0] CODE_PRECLR = 8'h80;
  localparam logic [CODE_W-1:0] CODE_CLR    = 8'h20;

  localparam int unsigned STEP_W   = 3;
  localparam int unsigned CLR_LAST = 5;
endpackage

// File: rtl/wps_match.sv
module wps_match
  import wps_pkg::*;
#(
  parameter int unsigned ADDR_W = 15,
  parameter int unsigned DATA_W = 8,
  parameter logic [ADDR_W-1:0] KEY_A = 15'h5555,
  parameter logic [ADDR_W-1:0] KEY_B = 15'h2AAA
) (
  input  logic [STEP_W-1:0] step_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              hit_o,
  output logic              set_done_o,
  output logic              clr_done_o
);
  logic at_a, at_b;
  logic [CODE_W-1:0] code;

  assign at_a = (addr_i == KEY_A);
  assign at_b = (addr_i == KEY_B);
  assign code = CODE_W'(data_i);

  always_comb begin
    hit_o      = 1'b0;
    set_done_o = 1'b0;
    clr_done_o = 1'b0;
    unique case (step_i)
      3'd0: hit_o = at_a && code == CODE_LEAD;
      3'd1: hit_o = at_b && code == CODE_FOLLOW;
      3'd2: begin
        // step 2 forks: arm ends here, disarm continues
        set_done_o = at_a && code == CODE_SET;
        hit_o      = at_a && (code == CODE_SET || code == CODE_PRECLR);
      end
      3'd3: hit_o = at_a && code == CODE_LEAD;
      3'd4: hit_o = at_b && code == CODE_FOLLOW;
      3'd5: begin
        hit_o      = at_a && code == CODE_CLR;
        clr_done_o = hit_o;
      end
      default: hit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/wps_window.sv
module wps_window #(
  parameter int unsigned LOAD_WINDOW = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic clear_i,
  output logic expired_o
);
  localparam int unsigned CNT_W = $clog2(LOAD_WINDOW + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LOAD_WINDOW - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (!run_i || clear_i)  cnt_q <= '0;
    else if (cnt_q != LAST)      cnt_q <= cnt_q + 1'b1;
  end

  assign expired_o = run_i && !clear_i && (cnt_q == LAST);
endmodule

// File: rtl/wps_flag.sv
module wps_flag
  import wps_pkg::*;
(
  input  logic      clk_i,
  input  logic      apply_i,
  input  wps_act_e  act_i,
  output logic      prot_o
);
  // retained across reset; only the power-up value is defined
  logic prot_q = 1'b0;

  always_ff @(posedge clk_i) begin
    if (apply_i) begin
      case (act_i)
        ACT_SET: prot_q <= 1'b1;
        ACT_CLR: prot_q <= 1'b0;
        default: prot_q <= prot_q;
      endcase
    end
  end

  assign prot_o = prot_q;
endmodule

// File: rtl/wps_seq.sv
module wps_seq
  import wps_pkg::*;
#(
  parameter int unsigned ADDR_W      = 15,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned LOAD_WINDOW = 16,
  parameter logic [ADDR_W-1:0] KEY_A = 15'h5555,
  parameter logic [ADDR_W-1:0] KEY_B = 15'h2AAA
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_valid_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              cycle_done_i,
  output logic              cmd_o,
  output logic              store_o,
  output logic              start_cycle_o,
  output logic              program_o,
  output logic              busy_o,
  output logic              prot_o
);
  wps_state_e       state_q;
  wps_act_e         act_q;
  logic [STEP_W-1:0] step_q;
  logic             data_q, stored_q;

  logic accept, matching, hit, set_done, clr_done, cmd, store, auth;
  logic expired, apply;

  wps_match #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .KEY_A(KEY_A), .KEY_B(KEY_B)
  ) u_match (
    .step_i    (step_q),
    .addr_i    (wr_addr_i),
    .data_i    (wr_data_i),
    .hit_o     (hit),
    .set_done_o(set_done),
    .clr_done_o(clr_done)
  );

  wps_window #(.LOAD_WINDOW(LOAD_WINDOW)) u_window (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (state_q == ST_LOAD),
    .clear_i  (accept),
    .expired_o(expired)
  );

  assign apply = (state_q == ST_BUSY) && cycle_done_i;

  wps_flag u_flag (
    .clk_i  (clk_i),
    .apply_i(apply),
    .act_i  (act_q),
    .prot_o (prot_o)
  );

  assign accept   = wr_valid_i && (state_q != ST_BUSY);
  // matching only before any data byte and before a completed sequence
  assign matching = accept && (act_q == ACT_NONE) && !data_q;
  assign cmd      = matching && hit;
  assign auth     = !prot_o || (act_q != ACT_NONE);
  assign store    = accept && !cmd && auth;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      act_q    <= ACT_NONE;
      step_q   <= '0;
      data_q   <= 1'b0;
      stored_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE, ST_LOAD: begin
          if (accept) begin
            state_q <= ST_LOAD;
            if (cmd) begin
              if (set_done) begin
                act_q  <= ACT_SET;
                step_q <= '0;
              end else if (clr_done) begin
                act_q  <= ACT_CLR;
                step_q <= '0;
              end else begin
                step_q <= step_q + 1'b1;
              end
            end else begin
              data_q <= 1'b1;
              step_q <= '0;
              if (store) stored_q <= 1'b1;
            end
          end else if (expired) begin
            if (act_q != ACT_NONE || data_q) begin
              state_q <= ST_BUSY;
            end else begin
              state_q <= ST_IDLE;
              step_q  <= '0;
            end
          end
        end
        ST_BUSY: begin
          if (cycle_done_i) begin
            state_q  <= ST_IDLE;
            act_q    <= ACT_NONE;
            step_q   <= '0;
            data_q   <= 1'b0;
            stored_q <= 1'b0;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cmd_o         = cmd;
  assign store_o       = store;
  assign start_cycle_o = expired && (act_q != ACT_NONE || data_q);
  assign program_o     = stored_q;
  assign busy_o        = (state_q == ST_BUSY);
endmodule

// File: rtl/wps_seq_chk.sv
module wps_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic wr_valid_i,
  input logic cycle_done_i,
  input logic cmd_o,
  input logic store_o,
  input logic start_cycle_o,
  input logic busy_o,
  input logic prot_o
);
  // R1
  cmd_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_o |-> (wr_valid_i && !store_o));

  // R7
  store_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    store_o |-> wr_valid_i);

  // R11
  busy_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (!cmd_o && !store_o));

  // R3
  prot_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && cycle_done_i) |=> $stable(prot_o));

  // R10
  start_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_cycle_o |=> (busy_o && !start_cycle_o));

  // R10
  start_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_cycle_o |-> (!busy_o && !wr_valid_i));
endmodule

bind wps_seq wps_seq_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .wr_valid_i   (wr_valid_i),
  .cycle_done_i (cycle_done_i),
  .cmd_o        (cmd_o),
  .store_o      (store_o),
  .start_cycle_o(start_cycle_o),
  .busy_o       (busy_o),
  .prot_o       (prot_o)
);

// File: tb/wps_seq_tb.sv
module wps_seq_tb;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned AW  = 15;
  localparam int unsigned DW  = 8;
  localparam int unsigned WIN = 8;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic wr_valid_i = 1'b0, cycle_done_i = 1'b0;
  logic [AW-1:0] wr_addr_i = '0;
  logic [DW-1:0] wr_data_i = '0;
  logic cmd_o, store_o, start_cycle_o, program_o, busy_o, prot_o;

  int total = 0, bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wps_seq #(.ADDR_W(AW), .DATA_W(DW), .LOAD_WINDOW(WIN)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_valid_i(wr_valid_i),
    .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i), .cycle_done_i(cycle_done_i),
    .cmd_o(cmd_o), .store_o(store_o), .start_cycle_o(start_cycle_o),
    .program_o(program_o), .busy_o(busy_o), .prot_o(prot_o)
  );

  // reference state: act 0 none, 1 arm, 2 disarm
  bit m_prot = 0, m_data = 0, m_stored = 0;
  int m_step = 0, m_act = 0;

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // 0 miss, 1 advance, 2 arm done, 3 disarm done
  function automatic int step_hit(int st, logic [AW-1:0] a, logic [DW-1:0] d);
    case (st)
      0: return (a == 15'h5555 && d == 8'hAA) ? 1 : 0;
      1: return (a == 15'h2AAA && d == 8'h55) ? 1 : 0;
      2: return (a != 15'h5555) ? 0 : (d == 8'hA0) ? 2 : (d == 8'h80) ? 1 : 0;
      3: return (a == 15'h5555 && d == 8'hAA) ? 1 : 0;
      4: return (a == 15'h2AAA && d == 8'h55) ? 1 : 0;
      5: return (a == 15'h5555 && d == 8'h20) ? 3 : 0;
      default: return 0;
    endcase
  endfunction

  task automatic put_byte(string req, logic [AW-1:0] a, logic [DW-1:0] d);
    int h;
    bit e_cmd, e_store;
    @(negedge clk);
    wr_valid_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    h = (m_act == 0 && !m_data) ? step_hit(m_step, a, d) : 0;
    e_cmd   = (h != 0);
    e_store = !e_cmd && (!m_prot || m_act != 0);
    #1;
    chk({req, " cmd"}, int'(cmd_o), int'(e_cmd));
    chk({req, " store"}, int'(store_o), int'(e_store));
    if (h == 1) m_step++;
    else if (h == 2) begin m_act = 1; m_step = 0; end
    else if (h == 3) begin m_act = 2; m_step = 0; end
    else begin m_data = 1; m_step = 0; if (e_store) m_stored = 1; end
  endtask

  task automatic close_load(string req);
    bit nonempty;
    int seen;
    nonempty = (m_act != 0) || m_data;
    seen = 0;
    for (int i = 1; i <= int'(WIN) + 3; i++) begin
      @(negedge clk);
      wr_valid_i = 1'b0;
      #1;
      if (start_cycle_o && seen == 0) begin
        seen = i;
        chk({req, " program"}, int'(program_o), int'(m_stored));
        break;
      end
    end
    if (nonempty) chk({req, " R10 close latency"}, seen, int'(WIN));
    else begin
      chk({req, " R9 no cycle"}, seen, 0);
      chk({req, " R9 idle"}, int'(busy_o), 0);
      m_step = 0;
    end
  endtask

  task automatic finish_cycle(string req);
    if (!((m_act != 0) || m_data)) return;
    @(negedge clk);
    #1;
    chk({req, " R10 busy"}, int'(busy_o), 1);
    chk({req, " flag before end"}, int'(prot_o), int'(m_prot));
    wr_valid_i = 1'b1; wr_addr_i = 15'h5555; wr_data_i = 8'hAA;
    #1;
    chk({req, " R11 busy cmd"}, int'(cmd_o), 0);
    chk({req, " R11 busy store"}, int'(store_o), 0);
    @(negedge clk);
    wr_valid_i = 1'b0; cycle_done_i = 1'b1;
    @(negedge clk);
    cycle_done_i = 1'b0;
    #1;
    if (m_act == 1) m_prot = 1;
    if (m_act == 2) m_prot = 0;
    m_act = 0; m_data = 0; m_stored = 0; m_step = 0;
    chk({req, " flag after end"}, int'(prot_o), int'(m_prot));
    chk({req, " R11 idle after"}, int'(busy_o), 0);
  endtask

  task automatic arm_seq(string req);
    put_byte(req, 15'h5555, 8'hAA);
    put_byte(req, 15'h2AAA, 8'h55);
    put_byte(req, 15'h5555, 8'hA0);
  endtask

  task automatic disarm_seq(string req);
    put_byte(req, 15'h5555, 8'hAA);
    put_byte(req, 15'h2AAA, 8'h55);
    put_byte(req, 15'h5555, 8'h80);
    put_byte(req, 15'h5555, 8'hAA);
    put_byte(req, 15'h2AAA, 8'h55);
    put_byte(req, 15'h5555, 8'h20);
  endtask

  task automatic rand_data(string req, int n);
    for (int k = 0; k < n; k++)
      put_byte(req, AW'($urandom_range(0, 32767)), DW'($urandom_range(0, 255)));
  endtask

  initial begin
    int kind;
    void'($urandom(32'd1234));
    #1;
    // R12 power-up state
    chk("R12 prot reset", int'(prot_o), 0);
    chk("R12 busy reset", int'(busy_o), 0);
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R7 plain writes unprotected
    put_byte("R7", 15'h0100, 8'h3C);
    put_byte("R7", 15'h0101, 8'hC3);
    close_load("R7"); finish_cycle("R7");

    // R1 R3 arm with no data
    arm_seq("R1");
    close_load("R3"); finish_cycle("R3");
    chk("R3 flag set", int'(prot_o), 1);

    // R5 protected write without prefix
    put_byte("R5", 15'h0200, 8'h11);
    close_load("R5"); finish_cycle("R5");
    chk("R5 flag kept", int'(prot_o), 1);

    // R6 R13 unlocked write, then repeated first step stored as data
    arm_seq("R6");
    put_byte("R6", 15'h0300, 8'h77);
    put_byte("R13", 15'h5555, 8'hAA);
    close_load("R6"); finish_cycle("R6");

    // R12 reset keeps flag
    @(negedge clk); rst_ni = 1'b0;
    @(negedge clk); #1;
    chk("R12 flag kept in reset", int'(prot_o), 1);
    rst_ni = 1'b1;

    // R9 partial sequence timeout, then R8 break while protected
    put_byte("R9", 15'h5555, 8'hAA);
    put_byte("R9", 15'h2AAA, 8'h55);
    close_load("R9");
    chk("R9 flag kept", int'(prot_o), 1);
    put_byte("R8", 15'h5555, 8'hAA);
    put_byte("R8", 15'h2AAA, 8'h00);
    close_load("R8"); finish_cycle("R8");

    // R2 R4 disarm with data
    disarm_seq("R2");
    put_byte("R4", 15'h0400, 8'h5A);
    close_load("R4"); finish_cycle("R4");
    chk("R4 flag cleared", int'(prot_o), 0);

    // R8 break on third step unprotected, next load matches afresh
    put_byte("R8", 15'h5555, 8'hAA);
    put_byte("R8", 15'h2AAA, 8'h55);
    put_byte("R8", 15'h5555, 8'h01);
    close_load("R8"); finish_cycle("R8");
    arm_seq("R8 fresh");
    close_load("R8"); finish_cycle("R8");

    // random sessions
    for (int s = 0; s < 60; s++) begin
      kind = $urandom_range(0, 4);
      case (kind)
        0: rand_data("R7 rnd", $urandom_range(1, 4));
        1: begin arm_seq("R6 rnd"); rand_data("R6 rnd", $urandom_range(0, 3)); end
        2: begin disarm_seq("R4 rnd"); rand_data("R4 rnd", $urandom_range(0, 3)); end
        3: begin
          put_byte("R8 rnd", 15'h5555, 8'hAA);
          if ($urandom_range(0, 1) == 1) put_byte("R8 rnd", 15'h2AAA, 8'h55);
          put_byte("R8 rnd", AW'($urandom_range(0, 32767)), 8'h00);
          rand_data("R8 rnd", $urandom_range(0, 2));
        end
        default: begin
          arm_seq("R13 rnd");
          put_byte("R13 rnd", 15'h5555, 8'hAA);
        end
      endcase
      close_load("rnd");
      finish_cycle("rnd");
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule